// File: doc/BRIEF.md
# Sawtooth Half-Bridge Gate Modulator

This block turns a current-loop error into gate commands for the two switches of a half-bridge converter. Each cycle it subtracts the sensed current from the reference current and scales the difference by an unsigned fixed-point gain. It then compares the magnitude of the scaled error with a sawtooth carrier that it generates itself. A positive error gives on-time to the upper switch. A negative error gives on-time to the lower switch. Because the carrier never goes below zero, only one of the two switches can be commanded on at a time.

The carrier is a counter that runs from zero up to a terminal count and then wraps to zero, so one period lasts terminal count plus one clock cycles. At a 100 MHz clock, a terminal count of 2499 gives a 40 kHz switching rate. The error sign, the saturated error magnitude and the terminal count are all captured on the wrap cycle. A change made in the middle of a period therefore takes effect only from the next period. A wrap pulse lets the surrounding control loop line its updates up with the carrier. An enable input shuts both gates off at once. Dead time and gate driving are handled outside this block.

Top module: `hb_saw_pwm`

## Requirements
- R1: The error is `i_ref - i_meas`, computed without overflow. It is multiplied by `gain`, an unsigned value with `GAIN_FRAC` (default 4) fraction bits, so 16 means unity. The magnitude of the product is then shifted right by `GAIN_FRAC`, which truncates positive and negative errors alike.
- R2: When the captured error is positive, `gate_hi` is high in the carrier cycles whose count is below the scaled magnitude, and `gate_lo` stays low.
- R3: When the captured error is negative, `gate_lo` is high in the carrier cycles whose count is below the scaled magnitude, and `gate_hi` stays low.
- R4: `gate_hi` and `gate_lo` are never high in the same cycle.
- R5: The carrier counts from 0 up to the captured terminal count and then returns to 0. `wrap` is high for the one cycle in which the count equals the terminal count, so wrap pulses are terminal count plus one cycles apart.
- R6: The error sign and magnitude are captured only in a wrap cycle. Input changes made in the middle of a period do not alter that period's gate pattern. A gate can turn on only in the first cycle of a period, unless enable has just risen.
- R7: A scaled magnitude greater than the terminal count keeps the relevant gate high for the whole period, which is 100% duty.
- R8: While `en` is low, both gates are low in that same cycle. The carrier keeps running.
- R9: While `rst_n` is low, both gates and `wrap` are low. The first cycle after reset is released is a wrap cycle, which captures the inputs.
- R10: A new `term_cnt` takes effect only at a wrap. The period already in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Gate enable; low forces both gates off |
| i_ref | input | CUR_W | Reference current, signed |
| i_meas | input | CUR_W | Sensed current, signed |
| gain | input | GAIN_W | Error gain, unsigned, GAIN_FRAC fraction bits |
| term_cnt | input | CNT_W | Carrier terminal count (period minus one) |
| gate_hi | output | 1 | Upper switch command |
| gate_lo | output | 1 | Lower switch command |
| wrap | output | 1 | High in the last cycle of each carrier period |

## Verification
The assertions check four things on every cycle: the two gates are never on together, enable low clears both gates, the counter never passes its captured terminal count, and the captured compare values and period hold steady between wraps. They also check that a gate rises only at the start of a period. The duty cycle itself can only be shown by the bench's scenarios. These measure gate on-time across whole periods for many error signs, gains and saturation levels, including the truncation of small errors, a mid-period input change and a mid-period change of terminal count.

// File: rtl/hb_saw_pwm.sv
module hb_saw_pwm #(
  parameter int CUR_W     = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int CNT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [CUR_W-1:0]  i_ref,
  input  logic signed [CUR_W-1:0]  i_meas,
  input  logic        [GAIN_W-1:0] gain,
  input  logic        [CNT_W-1:0]  term_cnt,
  output logic                     gate_hi,
  output logic                     gate_lo,
  output logic                     wrap
);
  localparam int ERR_W  = CUR_W + 1;
  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int MAG_W  = CNT_W + 1;
  localparam logic [MAG_W-1:0] MAG_MAX = {1'b1, {CNT_W{1'b0}}};

  logic signed [ERR_W-1:0]  err;
  logic signed [GAIN_W:0]   gain_s;
  logic signed [PROD_W-1:0] prod;
  logic        [PROD_W-1:0] prod_abs, scaled;
  logic        [MAG_W-1:0]  mag_next;

  logic [CNT_W-1:0] cnt_q, tc_q;
  logic [MAG_W-1:0] mag_q;
  logic             pos_q, neg_q, at_end;

  assign err      = ERR_W'(i_ref) - ERR_W'(i_meas);
  assign gain_s   = $signed({1'b0, gain});
  assign prod     = PROD_W'(err) * PROD_W'(gain_s);
  assign prod_abs = prod[PROD_W-1] ? $unsigned(-prod) : $unsigned(prod);
  assign scaled   = prod_abs >> GAIN_FRAC;
  assign mag_next = (scaled > PROD_W'(MAG_MAX)) ? MAG_MAX : scaled[MAG_W-1:0];

  assign at_end = (cnt_q == tc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= '0;
      mag_q <= '0;
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      tc_q  <= term_cnt;
      mag_q <= mag_next;
      pos_q <= ~prod[PROD_W-1];
      neg_q <= prod[PROD_W-1];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gate_hi = en & pos_q & ({1'b0, cnt_q} < mag_q);
  assign gate_lo = en & neg_q & ({1'b0, cnt_q} < mag_q);
  assign wrap    = rst_n & at_end;
endmodule

// File: rtl/hb_saw_pwm_chk.sv
module hb_saw_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             gate_hi,
  input logic             gate_lo,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc,
  input logic [CNT_W:0]   mag
);
  a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!gate_hi && !gate_lo));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= tc);

  a_r6_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(mag) && $stable(tc)));

  a_r2_hi_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && $past(en)) |-> $past(wrap));

  a_r3_lo_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo) && $past(en)) |-> $past(wrap));
endmodule

bind hb_saw_pwm hb_saw_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .wrap    (wrap),
  .cnt     (cnt_q),
  .tc      (tc_q),
  .mag     (mag_q)
);

// File: tb/hb_saw_pwm_tb.sv
module hb_saw_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int V_REF [NV] = '{5, 0, 4, 2, 3, 1, -1, 100, -300, 9, 10, -32768};
  localparam int V_MEAS[NV] = '{0, 3, 4, 0, 0, 0,  0,   0,  200, 0,  0,  32767};
  localparam int V_GAIN[NV] = '{16,16,16,32, 8, 8,  8,  16,   16,16, 16,  255};
  localparam int V_HI  [NV] = '{5, 0, 0, 4, 1, 0,  0,  10,    0, 9, 10,    0};
  localparam int V_LO  [NV] = '{0, 3, 0, 0, 0, 0,  0,   0,   10, 0,  0,   10};

  logic clk = 0, rst_n = 0, en = 1;
  logic signed [15:0] i_ref = 0, i_meas = 0;
  logic [7:0]  gain = 16;
  logic [15:0] term_cnt = 9;
  logic gate_hi, gate_lo, wrap;
  int checks = 0, failures = 0, tc_tb = 9;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_saw_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .i_ref(i_ref), .i_meas(i_meas),
    .gain(gain), .term_cnt(term_cnt), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .wrap(wrap)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_wrap();
    do @(negedge clk); while (!wrap);
  endtask

  task automatic run_period(output int hi, output int lo);
    hi = 0; lo = 0;
    wait_wrap();
    for (int i = 0; i <= tc_tb; i++) begin
      @(negedge clk);
      hi += int'(gate_hi); lo += int'(gate_lo);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    int hi, lo, n;
    i_ref = 16'sd100;
    repeat (3) @(negedge clk);
    check("R9 reset gate_hi", int'(gate_hi), 0);
    check("R9 reset gate_lo", int'(gate_lo), 0);
    check("R9 reset wrap", int'(wrap), 0);
    rst_n = 1;
    #1;
    check("R9 first cycle wraps", int'(wrap), 1);

    // R1 R2 R3 R4 R7: vector table, period of 10 cycles
    for (int v = 0; v < NV; v++) begin
      i_ref = 16'(V_REF[v]); i_meas = 16'(V_MEAS[v]); gain = 8'(V_GAIN[v]);
      run_period(hi, lo);
      check($sformatf("R1/R2 vec%0d hi cycles", v), hi, V_HI[v]);
      check($sformatf("R1/R3 vec%0d lo cycles", v), lo, V_LO[v]);
    end

    // R6: mid-period change ignored until next period
    i_ref = 5; i_meas = 0; gain = 16;
    run_period(hi, lo);
    wait_wrap();
    hi = 0;
    for (int i = 0; i <= tc_tb; i++) begin
      @(negedge clk);
      hi += int'(gate_hi);
      if (i == 1) i_ref = -7;
    end
    check("R6 period after mid change hi", hi, 5);
    run_period(hi, lo);
    check("R6 next period lo", lo, 7);
    check("R6 next period hi", hi, 0);

    // R8: enable low clears gates at once
    i_ref = 100;
    run_period(hi, lo);
    @(negedge clk);
    check("R8 gate on before disable", int'(gate_hi), 1);
    en = 0;
    #1;
    check("R8 gate_hi off same cycle", int'(gate_hi), 0);
    run_period(hi, lo);
    check("R8 disabled period hi", hi, 0);
    en = 1;

    // R10 R5: period change applies at wrap only
    wait_wrap();
    @(negedge clk);
    term_cnt = 4;
    n = 0;
    do begin @(negedge clk); n++; end while (!wrap);
    check("R10 old period completes", n, 9);
    n = 0;
    do begin @(negedge clk); n++; end while (!wrap);
    check("R5 new period length", n, 5);
    tc_tb = 4;
    i_ref = 3;
    run_period(hi, lo);
    check("R2 short period duty", hi, 3);
    i_ref = 5;
    run_period(hi, lo);
    check("R7 magnitude equal period saturates", hi, 5);
    i_ref = -6;
    run_period(hi, lo);
    check("R7 lower saturates", lo, 5);
    check("R4 upper idle", hi, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule